// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This block holds two independent down-counters, each 32 bits wide by default and each stepped once per cycle of the system clock. Software reaches all of its state through a small register bus: a control word, a reload value and a live count for each timer, and a pair of registers that hold interrupt causes and interrupt masks. Each timer can run in one of three ways. It can count freely through the full range and report elapsed time. It can produce a periodic tick by reloading itself. It can count down once and then stop.

Each timer is managed by a three-state machine. CH_OFF means the timer is disabled. CH_RUN means it is counting or reloading. CH_SPENT means it is a one-shot timer parked at zero. The transitions are:

- CH_OFF to CH_RUN when the enable bit is set.
- CH_RUN to CH_SPENT when the count reaches zero with reload off and no count write.
- CH_SPENT to CH_RUN on a count write, or when reload is turned on.
- CH_RUN or CH_SPENT back to CH_OFF when the enable bit is cleared.

An expiry sets that timer's sticky cause bit. A single level interrupt output is raised while any cause bit is set together with its mask bit.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, all registers read as zero, both timers are disabled, and `irq` is low.
- R2: The register map is as follows. Control is at 0x00, where bit 2i enables timer i and bit 2i+1 enables reload for timer i. The reload value of timer i is at 0x10+8i and its count at 0x14+8i. The cause register is at 0x20 and the mask register at 0x24, with bit i belonging to timer i. Reads return the stored values, and unmapped addresses read as zero.
- R3: An enabled timer that is not being written decrements its count by one on each clock. The first decrement comes on the edge after the edge that set the enable bit.
- R4: A disabled timer holds its count, and a count write to it still takes effect.
- R5: An enabled timer with reload on whose count is zero loads its reload value on the next clock. With a reload value N of 1 or more, expiries are therefore N+1 cycles apart.
- R6: With reload off, a count written as V (V at least 1) expires exactly once, V clocks after the write. The count then stays at zero.
- R7: A write to a count register loads the written value, taking priority over a decrement or reload in the same cycle.
- R8: An expiry is the step of a count from 1 to 0, and it sets cause bit i. A write to the cause register clears each bit written as 0 and keeps each bit written as 1. An expiry in the same cycle as a clear leaves the bit set.
- R9: `irq` is high exactly when some cause bit and the matching mask bit are both set.
- R10: With reload and count both all ones and reload on, the timer counts freely. All ones minus the count equals the number of clocks since enabling, and it wraps from 0 back to all ones.
- R11: The timers are independent. Activity on one never changes the count or cause bit of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each timer steps once per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (6) | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: OR of the masked cause bits |

## Verification
The checker module tests, on every cycle and for each timer, the following: decrement by one, holding while disabled, loading the reload value at zero, parking at zero in one-shot mode, priority of count writes, stickiness of cause bits and their link to a 1-to-0 count step, and a quiet `irq` while all masks are clear. The exact number of cycles from a count write to a one-shot expiry, and the N+1 spacing of periodic expiries, can only be shown by the bench's sweeps. The same holds for the same-cycle race between a clear and an expiry, the full mask and cause combinations on `irq`, and the wrap of a free-running counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_RUN   = 2'd1,
        CH_SPENT = 2'd2
    } ch_state_t;

    localparam int unsigned OFS_CTRL     = 'h00;
    localparam int unsigned OFS_RLD_BASE = 'h10;
    localparam int unsigned OFS_CNT_BASE = 'h14;
    localparam int unsigned OFS_STRIDE   = 8;

    function automatic int unsigned rld_ofs(input int unsigned idx);
        return OFS_RLD_BASE + OFS_STRIDE * idx;
    endfunction

    function automatic int unsigned cnt_ofs(input int unsigned idx);
        return OFS_CNT_BASE + OFS_STRIDE * idx;
    endfunction

    // cause follows the last per-timer pair, mask follows cause
    function automatic int unsigned cause_ofs(input int unsigned ntmr);
        return OFS_RLD_BASE + OFS_STRIDE * ntmr;
    endfunction

    function automatic int unsigned mask_ofs(input int unsigned ntmr);
        return cause_ofs(ntmr) + 4;
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         rld_en,
    input  logic [W-1:0] reload_val,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    output logic [W-1:0] cnt,
    output logic         expire
);

    localparam logic [W-1:0] ONE = W'(1);

    ch_state_t    state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         step;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (en) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (!en)
                    state_d = CH_OFF;
                else if (!cnt_wr && !rld_en && (cnt_q <= ONE))
                    state_d = CH_SPENT;
            end
            CH_SPENT: begin
                if (!en)
                    state_d = CH_OFF;
                else if (cnt_wr || rld_en)
                    state_d = CH_RUN;
            end
            default: state_d = CH_OFF;
        endcase
    end

    // outputs: next count and expiry strobe
    always_comb begin
        step   = en && ((state_q != CH_SPENT) || rld_en);
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (cnt_wr) begin
            cnt_d = cnt_wdata;
        end else if (step) begin
            if (cnt_q == '0) begin
                if (rld_en) cnt_d = reload_val;
            end else begin
                cnt_d  = cnt_q - ONE;
                expire = (cnt_q == ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W   = 32,
    parameter int NUM = 2,
    parameter int AW  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    wr_en,
    input  logic [W-1:0]            wdata,
    input  logic [NUM-1:0][W-1:0]   cnt,
    input  logic [NUM-1:0]          cause,
    output logic [NUM-1:0]          en,
    output logic [NUM-1:0]          rld_en,
    output logic [NUM-1:0][W-1:0]   reload,
    output logic [NUM-1:0]          cnt_wr,
    output logic [NUM-1:0]          mask,
    output logic                    cause_wr,
    output logic [W-1:0]            rdata
);

    localparam int CW = 2 * NUM;
    localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_CAUSE = AW'(cause_ofs(NUM));
    localparam logic [AW-1:0] A_MASK  = AW'(mask_ofs(NUM));

    logic [CW-1:0]          ctrl_q;
    logic [NUM-1:0]         mask_q;
    logic [NUM-1:0][W-1:0]  reload_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL) ctrl_q <= wdata[CW-1:0];
            if (addr == A_MASK) mask_q <= wdata[NUM-1:0];
        end
    end

    assign cause_wr = wr_en && (addr == A_CAUSE);
    assign mask     = mask_q;

    for (genvar i = 0; i < NUM; i++) begin : g_tmr
        localparam logic [AW-1:0] A_RLD = AW'(rld_ofs(i));
        localparam logic [AW-1:0] A_CNT = AW'(cnt_ofs(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reload_q[i] <= '0;
            end else if (wr_en && (addr == A_RLD)) begin
                reload_q[i] <= wdata;
            end
        end

        assign en[i]     = ctrl_q[2*i];
        assign rld_en[i] = ctrl_q[2*i+1];
        assign cnt_wr[i] = wr_en && (addr == A_CNT);
        assign reload[i] = reload_q[i];
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL)  rdata = W'(ctrl_q);
        if (addr == A_CAUSE) rdata = W'(cause);
        if (addr == A_MASK)  rdata = W'(mask_q);
        for (int i = 0; i < NUM; i++) begin
            if (addr == AW'(rld_ofs(i))) rdata = reload_q[i];
            if (addr == AW'(cnt_ofs(i))) rdata = cnt[i];
        end
    end

endmodule

// File: rtl/tmr_cause.sv
module tmr_cause #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_wr,
    input  logic [NUM-1:0] clr_data,
    input  logic [NUM-1:0] expire,
    input  logic [NUM-1:0] mask,
    output logic [NUM-1:0] cause,
    output logic           irq
);

    logic [NUM-1:0] cause_q, keep;

    // a 0 written clears the bit, a 1 leaves it; expiry always sets
    assign keep = clr_wr ? clr_data : '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= (cause_q & keep) | expire;
        end
    end

    assign cause = cause_q;
    assign irq   = |(cause_q & mask);

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
    parameter int W   = 32,
    parameter int NUM = 2,
    parameter int AW  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          irq
);

    logic [NUM-1:0]         tmr_en, tmr_rld, tmr_cnt_wr, tmr_expire;
    logic [NUM-1:0][W-1:0]  tmr_reload, tmr_cnt;
    logic [NUM-1:0]         cause_q, mask_q;
    logic                   cause_wr;

    tmr_regs #(.W(W), .NUM(NUM), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr_en    (bus_wr),
        .wdata    (bus_wdata),
        .cnt      (tmr_cnt),
        .cause    (cause_q),
        .en       (tmr_en),
        .rld_en   (tmr_rld),
        .reload   (tmr_reload),
        .cnt_wr   (tmr_cnt_wr),
        .mask     (mask_q),
        .cause_wr (cause_wr),
        .rdata    (bus_rdata)
    );

    for (genvar i = 0; i < NUM; i++) begin : g_ch
        tmr_channel #(.W(W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (tmr_en[i]),
            .rld_en     (tmr_rld[i]),
            .reload_val (tmr_reload[i]),
            .cnt_wr     (tmr_cnt_wr[i]),
            .cnt_wdata  (bus_wdata),
            .cnt        (tmr_cnt[i]),
            .expire     (tmr_expire[i])
        );
    end

    tmr_cause #(.NUM(NUM)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_wr   (cause_wr),
        .clr_data (bus_wdata[NUM-1:0]),
        .expire   (tmr_expire),
        .mask     (mask_q),
        .cause    (cause_q),
        .irq      (irq)
    );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int W   = 32,
    parameter int NUM = 2,
    parameter int AW  = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM-1:0]         tmr_en,
    input logic [NUM-1:0]         tmr_rld,
    input logic [NUM-1:0][W-1:0]  tmr_reload,
    input logic [NUM-1:0][W-1:0]  tmr_cnt,
    input logic [NUM-1:0]         tmr_cnt_wr,
    input logic [W-1:0]           bus_wdata,
    input logic [NUM-1:0]         cause_q,
    input logic [NUM-1:0]         mask_q,
    input logic                   cause_wr,
    input logic                   irq
);

    localparam logic [W-1:0] ONE = W'(1);

    for (genvar g = 0; g < NUM; g++) begin : g_chk
        AST_COUNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_en[g] && !tmr_cnt_wr[g] && tmr_cnt[g] > ONE)
            |=> tmr_cnt[g] == $past(tmr_cnt[g]) - ONE); // R3

        AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            (!tmr_en[g] && !tmr_cnt_wr[g]) |=> $stable(tmr_cnt[g])); // R4

        AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_en[g] && tmr_rld[g] && !tmr_cnt_wr[g] && tmr_cnt[g] == '0)
            |=> tmr_cnt[g] == $past(tmr_reload[g])); // R5

        AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
            (!tmr_rld[g] && !tmr_cnt_wr[g] && tmr_cnt[g] == '0)
            |=> tmr_cnt[g] == '0); // R6

        AST_COUNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_cnt_wr[g] |=> tmr_cnt[g] == $past(bus_wdata)); // R7

        AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_q[g] && !cause_wr) |=> cause_q[g]); // R8

        AST_CAUSE_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_en[g] && !tmr_cnt_wr[g] && tmr_cnt[g] == ONE) |=> cause_q[g]); // R8

        AST_CAUSE_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cause_q[g]) |-> $past(tmr_en[g] && tmr_cnt[g] == ONE)); // R8
    end

    AST_IRQ_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R9

endmodule

bind dual_reload_timer tmr_checker #(.W(W), .NUM(NUM), .AW(AW)) u_tmr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_en     (tmr_en),
    .tmr_rld    (tmr_rld),
    .tmr_reload (tmr_reload),
    .tmr_cnt    (tmr_cnt),
    .tmr_cnt_wr (tmr_cnt_wr),
    .bus_wdata  (bus_wdata),
    .cause_q    (cause_q),
    .mask_q     (mask_q),
    .cause_wr   (cause_wr),
    .irq        (irq)
);

// File: tb/test_dual_reload_timer.sv
`timescale 1ns/1ps
module test_dual_reload_timer;

    localparam logic [5:0] A_CTRL = 6'h00, A_RLD0 = 6'h10, A_CNT0 = 6'h14,
                           A_RLD1 = 6'h18, A_CNT1 = 6'h1C, A_CAUSE = 6'h20,
                           A_MASK = 6'h24, A_NONE = 6'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    dual_reload_timer i_dual_reload_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    logic [31:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_RLD0, v);  chk("R1 reload0", v, 0);
        rd(A_CNT0, v);  chk("R1 count0", v, 0);
        rd(A_RLD1, v);  chk("R1 reload1", v, 0);
        rd(A_CNT1, v);  chk("R1 count1", v, 0);
        rd(A_CAUSE, v); chk("R1 cause", v, 0);
        rd(A_MASK, v);  chk("R1 mask", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 map and readback
        wr(A_RLD0, 32'h1234_5678); rd(A_RLD0, v); chk("R2 reload0", v, 32'h1234_5678);
        wr(A_RLD1, 32'h0000_CAFE); rd(A_RLD1, v); chk("R2 reload1", v, 32'h0000_CAFE);
        wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, v); chk("R2 mask width", v, 3);
        wr(A_MASK, 0);
        rd(A_NONE, v); chk("R2 unmapped", v, 0);
        wr(A_CTRL, 32'hA); rd(A_CTRL, v); chk("R2 ctrl", v, 32'hA);

        // R4 disabled timers hold, count write still lands
        wr(A_CNT1, 77); wr(A_CNT0, 55);
        repeat (10) @(negedge clk);
        rd(A_CNT1, v); chk("R4 hold t1", v, 77);
        rd(A_CNT0, v); chk("R4 hold t0", v, 55);
        wr(A_CTRL, 0);

        // R3 decrement
        wr(A_CNT0, 500);
        wr(A_CTRL, 32'h1);
        rd(A_CNT0, v); chk("R3 first edge", v, 500);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            rd(A_CNT0, v); chk("R3 decrement", v, 500 - k);
        end
        rd(A_CNT1, v); chk("R11 t1 untouched", v, 77);

        // R7 count write beats decrement
        wr(A_CNT0, 1000); rd(A_CNT0, v); chk("R7 write wins", v, 1000);
        @(negedge clk); rd(A_CNT0, v); chk("R7 then counts", v, 999);

        // R6 one-shot sweep
        for (int V = 1; V <= 8; V++) begin
            int k;
            wr(A_CAUSE, 0);
            wr(A_CNT0, V);
            k = 0;
            do begin
                @(negedge clk); k++;
                rd(A_CAUSE, v);
            end while (!v[0] && k < 30);
            chk("R6 expiry delay", k, V);
            chk("R8 only t0 cause", v, 1);
            repeat (4) @(negedge clk);
            rd(A_CNT0, v); chk("R6 parked", v, 0);
            wr(A_CAUSE, 0);
            repeat (3) @(negedge clk);
            rd(A_CAUSE, v); chk("R6 single expiry", v, 0);
        end

        // R5 periodic sweep on timer 1
        for (int N = 1; N <= 6; N++) begin
            int t_prev, nseen;
            wr(A_CTRL, 0);
            wr(A_RLD1, N); wr(A_CNT1, N); wr(A_CAUSE, 0);
            wr(A_CTRL, 32'hC);
            t_prev = 0; nseen = 0;
            while (nseen < 3) begin
                @(negedge clk);
                rd(A_CAUSE, v);
                if (cyc > 40000) break;
                if (v[1]) begin
                    chk("R11 t0 quiet", {31'd0, v[0]}, 0);
                    if (nseen > 0) chk("R5 period", cyc - t_prev, N + 1);
                    t_prev = cyc; nseen++;
                    wr(A_CAUSE, 0);
                end
            end
        end

        // R8 expiry wins over same-cycle clear; write-1 keeps
        wr(A_CTRL, 32'h1); wr(A_CAUSE, 0);
        wr(A_CNT0, 3);
        repeat (2) @(negedge clk);
        wr(A_CAUSE, 0);
        rd(A_CAUSE, v); chk("R8 expiry beats clear", v, 1);
        wr(A_CAUSE, 1); rd(A_CAUSE, v); chk("R8 write 1 keeps", v, 1);
        wr(A_CAUSE, 0); rd(A_CAUSE, v); chk("R8 write 0 clears", v, 0);

        // R9 irq over mask x cause
        wr(A_CTRL, 32'h5); wr(A_CNT0, 2); wr(A_CNT1, 4);
        repeat (6) @(negedge clk);
        rd(A_CAUSE, v); chk("R8 both causes", v, 3);
        for (int m = 0; m < 4; m++) begin
            wr(A_MASK, m);
            chk("R9 irq both set", {31'd0, irq}, (m != 0) ? 1 : 0);
        end
        wr(A_CAUSE, 32'h2); rd(A_CAUSE, v); chk("R8 selective clear", v, 2);
        for (int m = 0; m < 4; m++) begin
            wr(A_MASK, m);
            chk("R9 irq t1 only", {31'd0, irq}, (m >= 2) ? 1 : 0);
        end
        wr(A_MASK, 0); wr(A_CAUSE, 0);

        // R10 free-running
        wr(A_CTRL, 0);
        wr(A_RLD1, 32'hFFFF_FFFF); wr(A_CNT1, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'hC);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            rd(A_CNT1, v); chk("R10 elapsed", 32'hFFFF_FFFF - v, k);
        end
        wr(A_CNT1, 1);
        @(negedge clk); rd(A_CNT1, v); chk("R10 reaches zero", v, 0);
        @(negedge clk); rd(A_CNT1, v); chk("R10 wraps", v, 32'hFFFF_FFFF);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule